// File: doc/BRIEF.md
# Capability load permission filter

This block sits at the end of the load-result path of a capability-aware pipeline. A capability load presents the loaded value to the block. That value is a tag, a sealed flag, a flat permission vector and the remaining payload bits. The block also receives the permission vector of the authorizing capability. It decides the tag that the destination register receives and captures the result into a destination holding stage. Plain capability loads and load-reserved capability loads use the same port and follow the same rules.

When the authority lacks the load-mutable permission, the block does not mask the loaded permissions at once. It stores the raw bits together with one pending "strip" flag. Consumers that dereference the capability or read its metadata use the inspection port. That port shows the permissions with write, load-mutable and any permission that depends on them removed. A normalization request folds the mask into the stored bits and clears the flag.

The destination stage is a three-state machine:
- `ST_EMPTY`: nothing captured since reset.
- `ST_CLEAN`: the stored bits are final.
- `ST_PENDING`: a strip is still owed.

Its transitions are:
- `T_LOAD_CLEAN`: any state to `ST_CLEAN`, on a load whose pending bit is 0.
- `T_LOAD_PEND`: any state to `ST_PENDING`, on a load whose pending bit is 1.
- `T_NORMALIZE`: `ST_PENDING` to `ST_CLEAN`, on a normalize request with no load in the same cycle.
- `T_HOLD`: the state stays as it is, in every other case.

Permission bit positions are R=0, W=1, C=2, X=3, ASR=4, LM=5. The all-permissions value is 0x3F.

Top module: `cap_load_filter`

## Requirements
- R1: One cycle after a load, `dst_tag` is 0 if `mem_tag` was 0 or the authority lacked C (bit 2). Otherwise it is 1.
- R2: One cycle after a load, `dst_pending` is 1 exactly when the resulting tag is 1, `mem_sealed` is 0 and the authority lacks LM (bit 5).
- R3: An untagged or sealed loaded value is never modified. Both `dst_raw_perms` and `insp_perms` equal the loaded permissions, whatever the authority's LM bit.
- R4: On a load, `dst_raw_perms` takes the loaded permissions unmodified, even when the pending flag is set.
- R5: While `dst_pending` is 1, `insp_perms` equals the raw bits with W (bit 1) and LM (bit 5) cleared. ASR (bit 4) is also cleared, because ASR is legal only together with W. All other bits are kept. While `dst_pending` is 0, `insp_perms` equals `dst_raw_perms`.
- R6: In `ST_PENDING`, `norm_req` without `ld_valid` writes the masked view into `dst_raw_perms` and clears `dst_pending` one cycle later. When `ld_valid` and `norm_req` arrive together, the load wins.
- R7: After reset, `dst_valid`, `dst_tag`, `dst_sealed`, `dst_pending`, `dst_raw_perms` and `insp_perms` are all 0.
- R8: `dst_sealed` and `dst_payload` carry the loaded sealed flag and payload unchanged, and `dst_valid` is 1 after the first load.
- R9: For every combination of authority permissions, memory tag and sealed flag, the inspected tag and permissions equal the result of applying the mask eagerly at load time.
- R10: `norm_req` outside `ST_PENDING` changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A capability load result is presented this cycle |
| auth_perms | input | 6 | Permission vector of the authorizing capability |
| mem_tag | input | 1 | Tag read from memory |
| mem_sealed | input | 1 | Sealed flag of the loaded value |
| mem_perms | input | 6 | Permission vector of the loaded value |
| mem_payload | input | PAYLOAD_W | Remaining bits of the loaded value |
| norm_req | input | 1 | Fold a pending strip into the stored bits |
| dst_valid | output | 1 | Destination holds a loaded value |
| dst_tag | output | 1 | Destination tag |
| dst_sealed | output | 1 | Destination sealed flag |
| dst_pending | output | 1 | Strip of W and LM is still owed |
| dst_raw_perms | output | 6 | Stored permission bits |
| dst_payload | output | PAYLOAD_W | Stored payload bits |
| insp_perms | output | 6 | Permissions as seen by dereference or metadata reads |
| insp_tag | output | 1 | Tag as seen by dereference or metadata reads |

## Verification
The assertions assume that `ld_valid` and `norm_req` are free of unknowns after reset. They also assume that the authority vector and loaded fields are only meaningful in cycles where `ld_valid` is 1. The properties therefore sample those inputs only under `ld_valid`. The stimulus drives every input to a defined value on each falling edge and keeps each load to a single cycle. Normalize requests come both alone and together with loads, so the load-priority corner is reached without undefined inputs.

// File: rtl/cap_ldf_pkg.sv
package cap_ldf_pkg;
    localparam int PERM_W = 6;
    localparam int P_R    = 0;
    localparam int P_W    = 1;
    localparam int P_C    = 2;
    localparam int P_X    = 3;
    localparam int P_ASR  = 4;
    localparam int P_LM   = 5;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_CLEAN   = 2'd1,
        ST_PENDING = 2'd2
    } dst_state_e;
endpackage

// File: rtl/ldf_tag_gate.sv
module ldf_tag_gate
    import cap_ldf_pkg::*;
(
    input  logic [PERM_W-1:0] auth_perms,
    input  logic              mem_tag,
    input  logic              mem_sealed,
    output logic              res_tag,
    output logic              res_pending
);
    // Tag survives only with capability-access authority.
    always_comb begin
        res_tag     = mem_tag & auth_perms[P_C];
        // Evaluated on the already-gated tag.
        res_pending = res_tag & ~mem_sealed & ~auth_perms[P_LM];
    end
endmodule

// File: rtl/ldf_perm_restrict.sv
module ldf_perm_restrict
    import cap_ldf_pkg::*;
(
    input  logic [PERM_W-1:0] perms_in,
    input  logic              strip,
    output logic [PERM_W-1:0] perms_out
);
    // W and LM are removed directly; ASR falls out with W by legalization.
    localparam logic [PERM_W-1:0] DROP_MASK =
        PERM_W'((1 << P_W) | (1 << P_LM) | (1 << P_ASR));

    for (genvar i = 0; i < PERM_W; i++) begin : g_bit
        if (DROP_MASK[i]) begin : g_drop
            assign perms_out[i] = perms_in[i] & ~strip;
        end else begin : g_keep
            assign perms_out[i] = perms_in[i];
        end
    end
endmodule

// File: rtl/cap_load_filter.sv
module cap_load_filter
    import cap_ldf_pkg::*;
#(
    parameter int PAYLOAD_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_valid,
    input  logic [PERM_W-1:0]    auth_perms,
    input  logic                 mem_tag,
    input  logic                 mem_sealed,
    input  logic [PERM_W-1:0]    mem_perms,
    input  logic [PAYLOAD_W-1:0] mem_payload,
    input  logic                 norm_req,
    output logic                 dst_valid,
    output logic                 dst_tag,
    output logic                 dst_sealed,
    output logic                 dst_pending,
    output logic [PERM_W-1:0]    dst_raw_perms,
    output logic [PAYLOAD_W-1:0] dst_payload,
    output logic [PERM_W-1:0]    insp_perms,
    output logic                 insp_tag
);
    dst_state_e           state_q, state_d;
    logic                 res_tag, res_pending;
    logic                 tag_q, sealed_q;
    logic [PERM_W-1:0]    perms_q, masked_perms;
    logic [PAYLOAD_W-1:0] payload_q;
    logic                 do_norm;

    ldf_tag_gate u_gate (
        .auth_perms (auth_perms),
        .mem_tag    (mem_tag),
        .mem_sealed (mem_sealed),
        .res_tag    (res_tag),
        .res_pending(res_pending)
    );

    ldf_perm_restrict u_restrict (
        .perms_in (perms_q),
        .strip    (state_q == ST_PENDING),
        .perms_out(masked_perms)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        do_norm = 1'b0;
        unique case (state_q)
            ST_EMPTY, ST_CLEAN: begin
                if (ld_valid) state_d = res_pending ? ST_PENDING : ST_CLEAN;
            end
            ST_PENDING: begin
                if (ld_valid) begin
                    state_d = res_pending ? ST_PENDING : ST_CLEAN;
                end else if (norm_req) begin
                    state_d = ST_CLEAN;
                    do_norm = 1'b1;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Destination data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q     <= 1'b0;
            sealed_q  <= 1'b0;
            perms_q   <= '0;
            payload_q <= '0;
        end else if (ld_valid) begin
            tag_q     <= res_tag;
            sealed_q  <= mem_sealed;
            perms_q   <= mem_perms;
            payload_q <= mem_payload;
        end else if (do_norm) begin
            perms_q   <= masked_perms;
        end
    end

    // Outputs
    always_comb begin
        dst_valid     = (state_q != ST_EMPTY);
        dst_pending   = (state_q == ST_PENDING);
        dst_tag       = tag_q;
        dst_sealed    = sealed_q;
        dst_raw_perms = perms_q;
        dst_payload   = payload_q;
        insp_perms    = masked_perms;
        insp_tag      = tag_q;
    end
endmodule

// File: rtl/cap_load_filter_checker.sv
module cap_load_filter_checker
    import cap_ldf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic [PERM_W-1:0] auth_perms,
    input logic              mem_tag,
    input logic              mem_sealed,
    input logic [PERM_W-1:0] mem_perms,
    input logic              norm_req,
    input logic              dst_tag,
    input logic              dst_pending,
    input logic [PERM_W-1:0] dst_raw_perms,
    input logic [PERM_W-1:0] insp_perms
);
    p_tag_needs_c_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && (!auth_perms[P_C] || !mem_tag)) |=> !dst_tag);

    p_pending_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && mem_tag && auth_perms[P_C] && !auth_perms[P_LM] && !mem_sealed)
        |=> dst_pending);

    p_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && (!mem_tag || mem_sealed))
        |=> (!dst_pending && insp_perms == $past(mem_perms)));

    p_raw_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> dst_raw_perms == $past(mem_perms));

    p_view_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dst_pending |-> (!insp_perms[P_W] && !insp_perms[P_LM] && !insp_perms[P_ASR]));

    p_normalize_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_pending && norm_req && !ld_valid)
        |=> (!dst_pending && dst_raw_perms == $past(insp_perms)));

    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dst_pending && !ld_valid) |=> $stable(dst_raw_perms));
endmodule

bind cap_load_filter cap_load_filter_checker ck_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_valid     (ld_valid),
    .auth_perms   (auth_perms),
    .mem_tag      (mem_tag),
    .mem_sealed   (mem_sealed),
    .mem_perms    (mem_perms),
    .norm_req     (norm_req),
    .dst_tag      (dst_tag),
    .dst_pending  (dst_pending),
    .dst_raw_perms(dst_raw_perms),
    .insp_perms   (insp_perms)
);

// File: tb/cap_load_filter_tb_top.sv
module cap_load_filter_tb_top;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [5:0]    auth_perms = '0;
    logic          mem_tag = 1'b0;
    logic          mem_sealed = 1'b0;
    logic [5:0]    mem_perms = '0;
    logic [PW-1:0] mem_payload = '0;
    logic          norm_req = 1'b0;
    logic          dst_valid, dst_tag, dst_sealed, dst_pending, insp_tag;
    logic [5:0]    dst_raw_perms, insp_perms;
    logic [PW-1:0] dst_payload;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cap_load_filter #(.PAYLOAD_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .auth_perms(auth_perms),
        .mem_tag(mem_tag), .mem_sealed(mem_sealed), .mem_perms(mem_perms),
        .mem_payload(mem_payload), .norm_req(norm_req), .dst_valid(dst_valid),
        .dst_tag(dst_tag), .dst_sealed(dst_sealed), .dst_pending(dst_pending),
        .dst_raw_perms(dst_raw_perms), .dst_payload(dst_payload),
        .insp_perms(insp_perms), .insp_tag(insp_tag)
    );

    function automatic logic exp_tag(logic [5:0] a, logic t);
        return t & a[2];
    endfunction
    function automatic logic exp_pend(logic [5:0] a, logic t, logic s);
        return exp_tag(a, t) & ~s & ~a[5];
    endfunction
    // Eager filter: strip W(1), LM(5) and dependent ASR(4).
    function automatic logic [5:0] exp_view(logic [5:0] a, logic t, logic s, logic [5:0] p);
        if (exp_pend(a, t, s)) return p & 6'b001101;
        return p;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(logic [5:0] a, logic t, logic s, logic [5:0] p,
                           logic [PW-1:0] pl, logic nr);
        @(negedge clk);
        ld_valid = 1'b1; auth_perms = a; mem_tag = t; mem_sealed = s;
        mem_perms = p; mem_payload = pl; norm_req = nr;
        @(negedge clk);
        ld_valid = 1'b0; norm_req = 1'b0;
    endtask

    task automatic check_load(logic [5:0] a, logic t, logic s, logic [5:0] p, logic [PW-1:0] pl);
        check("R1 tag", dst_tag, exp_tag(a, t));
        check("R2 pending", dst_pending, exp_pend(a, t, s));
        check("R4 raw perms", dst_raw_perms, p);
        check("R9 view vs eager", {insp_tag, insp_perms}, {exp_tag(a, t), exp_view(a, t, s, p)});
        check("R8 sealed/payload/valid", {dst_valid, dst_sealed, dst_payload}, {1'b1, s, pl});
        if (!t || s) check("R3 untouched", insp_perms, p);
        if (!exp_pend(a, t, s)) check("R5 unmasked view", insp_perms, dst_raw_perms);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        check("R7 reset", {dst_valid, dst_tag, dst_sealed, dst_pending, dst_raw_perms, insp_perms}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        norm_req = 1'b1;
        @(negedge clk);
        norm_req = 1'b0;
        check("R10 norm while empty", {dst_valid, dst_pending, dst_raw_perms}, 0);

        // Directed corners
        do_load(6'h3F, 1'b1, 1'b0, 6'h3F, 16'hA5A5, 1'b0);
        check_load(6'h3F, 1'b1, 1'b0, 6'h3F, 16'hA5A5);
        do_load(6'h1F, 1'b1, 1'b0, 6'h3F, 16'h1234, 1'b0);
        check_load(6'h1F, 1'b1, 1'b0, 6'h3F, 16'h1234);
        check("R5 masked view", insp_perms, 6'h0D);
        do_load(6'h1F, 1'b1, 1'b1, 6'h3F, 16'h0001, 1'b0);
        check_load(6'h1F, 1'b1, 1'b1, 6'h3F, 16'h0001);
        do_load(6'h1B, 1'b1, 1'b0, 6'h3F, 16'h0002, 1'b0);
        check_load(6'h1B, 1'b1, 1'b0, 6'h3F, 16'h0002);

        // Normalization
        do_load(6'h07, 1'b1, 1'b0, 6'h37, 16'h0BEE, 1'b0);
        check("R6 pending before norm", {dst_pending, dst_raw_perms}, {1'b1, 6'h37});
        @(negedge clk); norm_req = 1'b1;
        @(negedge clk); norm_req = 1'b0;
        check("R6 normalized", {dst_pending, dst_raw_perms, insp_perms}, {1'b0, 6'h05, 6'h05});
        @(negedge clk); norm_req = 1'b1;
        @(negedge clk); norm_req = 1'b0;
        check("R10 norm while clean", {dst_pending, dst_raw_perms}, {1'b0, 6'h05});
        do_load(6'h07, 1'b1, 1'b0, 6'h3A, 16'h0C0C, 1'b0);
        do_load(6'h3F, 1'b1, 1'b0, 6'h3E, 16'h0D0D, 1'b1);
        check("R6 load beats norm", {dst_pending, dst_raw_perms, insp_perms}, {1'b0, 6'h3E, 6'h3E});

        // Exhaustive authority x tag x sealed
        for (int a = 0; a < 64; a++) begin
            for (int ts = 0; ts < 4; ts++) begin
                logic [5:0] p;
                logic [PW-1:0] pl;
                p = 6'($urandom);
                pl = PW'($urandom);
                do_load(6'(a), ts[0], ts[1], p, pl, 1'b0);
                check_load(6'(a), ts[0], ts[1], p, pl);
            end
        end

        // Random mix with normalization requests
        for (int i = 0; i < 200; i++) begin
            logic [5:0] a, p;
            logic t, s;
            logic [PW-1:0] pl;
            a = 6'($urandom); p = 6'($urandom);
            t = 1'($urandom); s = 1'($urandom); pl = PW'($urandom);
            do_load(a, t, s, p, pl, 1'($urandom));
            check_load(a, t, s, p, pl);
            if ($urandom % 2 == 0) begin
                @(negedge clk); norm_req = 1'b1;
                @(negedge clk); norm_req = 1'b0;
                check("R6 random norm", {dst_pending, dst_raw_perms, insp_perms},
                      {1'b0, exp_view(a, t, s, p), exp_view(a, t, s, p)});
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule